// File: doc/BRIEF.md
# Clock Generator Configuration Register with Cross-Domain Status

This block is the 8-bit control and status register of an on-chip clock generator. Software writes three settings on the bus clock: a two-bit oscillator range request, a flag that tunes the oscillator for best top frequency on a 32.768 kHz reference, and a fine-trim bit. The block carries these settings into the generator clock domain, where they appear on dedicated outputs. A separate level input asks for the internal or the external reference.

Reads do not simply echo what was written. The range field and the reference bit report the values that the generator domain has actually adopted. These values come back through a synchronizer, so they trail the request by a few cycles of each clock. The two-bit range moves with a toggle request/acknowledge handshake, so that a half-updated code never shows. Range writes that use the reserved code, or that arrive while the low-power input is high, are dropped silently. The fine-trim bit takes its start value from a factory trim input during reset. If the debug input is high during reset, it takes 0 instead.

Top module: `clkcfg_reg`

## Requirements
- R1: During reset, and until the first bus write, `rd_data` reads 8'h10 with bit 0 equal to the fine-trim reset value. In the generator domain, `gen_range` is 0, `gen_maxfreq` is 0 and `gen_ref_int` is 1.
- R2: A write whose bits 7:6 hold 00 (low), 01 (mid) or 10 (high) is applied to `gen_range` and then shown in `rd_data[7:6]`. The read field does not change in the bus cycle that follows the write.
- R3: A write whose bits 7:6 hold 11 leaves both `gen_range` and `rd_data[7:6]` at their previous value.
- R4: While `low_power` is 1, bits 7:6 of any write are ignored. The other bits of the same write still take effect.
- R5: Bit 5 of a write is stored, reads back at `rd_data[5]`, and reaches `gen_maxfreq` after synchronization.
- R6: During reset, bit 0 loads `trim_fuse`, or 0 when `debug_mode` is 1. Afterwards it is writable through `wr_data[0]`, reads at `rd_data[0]`, and reaches `gen_ftrim`.
- R7: `rd_data[4]` shows the reference adopted by the generator domain: 1 for internal, 0 for external. It follows `ref_int_req` only after a round trip through the generator domain, so it does not change in the bus cycle after `ref_int_req` changes.
- R8: A range write that arrives while an earlier range transfer is still in flight is held and sent afterwards. In that case `rd_data[7:6]` only ever shows the old value or one of the accepted values, and it ends at the last accepted value.
- R9: `rd_data[3:1]` always reads 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low bus-domain reset |
| gen_clk | input | 1 | Generator clock |
| gen_rst_n | input | 1 | Active-low generator-domain reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read value: {range status, max-freq, ref status, 000, fine trim} |
| low_power | input | 1 | Blocks range writes when high |
| ref_int_req | input | 1 | Requests the internal (1) or external (0) reference |
| trim_fuse | input | 1 | Factory fine-trim value, sampled during reset |
| debug_mode | input | 1 | Forces fine trim to 0 during reset |
| gen_range | output | 2 | Range applied in the generator domain |
| gen_maxfreq | output | 1 | Max-frequency tuning applied in the generator domain |
| gen_ftrim | output | 1 | Fine trim applied in the generator domain |
| gen_ref_int | output | 1 | Reference selection applied in the generator domain |

## Verification
A broken write filter shows within one handshake round trip, about a dozen cycles. In that case `gen_range` takes 11, or takes a value written under low power, and `rd_data[7:6]` then reports it. A lost toggle or a wrong acknowledge edge leaves the range status stuck at an old code, or makes it skip the final code of back-to-back writes. Waiting several dozen cycles after each write exposes this. A wrong synchronizer reset value or a wrong fine-trim load is visible at `rd_data` straight after reset. Status that skips the round trip shows as a change in the bus cycle right after the stimulus.

// File: rtl/clkcfg_reg.sv
module clkcfg_reg (
  input  logic       bus_clk,
  input  logic       bus_rst_n,
  input  logic       gen_clk,
  input  logic       gen_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       low_power,
  input  logic       ref_int_req,
  input  logic       trim_fuse,
  input  logic       debug_mode,
  output logic [1:0] gen_range,
  output logic       gen_maxfreq,
  output logic       gen_ftrim,
  output logic       gen_ref_int
);

  logic [1:0] range_req, sent_range, range_stat;
  logic       req_tgl, ack_m, ack_s, ack_seen;
  logic       maxfreq, ftrim;
  logic       refst_m, refst_s;
  logic       req_m, req_s, ack_tgl;
  logic       mf_m, ft_m, rq_m;

  wire range_ok = wr_en && !low_power && (wr_data[7:6] != 2'b11);
  wire xfer_idle = (req_tgl == ack_seen) && (ack_s == ack_seen);

  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      range_req <= 2'b00;
      maxfreq   <= 1'b0;
    end else if (wr_en) begin
      if (range_ok) range_req <= wr_data[7:6];
      maxfreq <= wr_data[5];
    end

  always_ff @(posedge bus_clk)
    if (!bus_rst_n)  ftrim <= debug_mode ? 1'b0 : trim_fuse;
    else if (wr_en)  ftrim <= wr_data[0];

  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      sent_range <= 2'b00;
      req_tgl    <= 1'b0;
    end else if (xfer_idle && (range_req != sent_range)) begin
      sent_range <= range_req;
      req_tgl    <= ~req_tgl;
    end

  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      ack_m      <= 1'b0;
      ack_s      <= 1'b0;
      ack_seen   <= 1'b0;
      range_stat <= 2'b00;
      refst_m    <= 1'b1;
      refst_s    <= 1'b1;
    end else begin
      ack_m    <= ack_tgl;
      ack_s    <= ack_m;
      ack_seen <= ack_s;
      if (ack_s != ack_seen) range_stat <= sent_range;
      refst_m  <= gen_ref_int;
      refst_s  <= refst_m;
    end

  always_ff @(posedge gen_clk or negedge gen_rst_n)
    if (!gen_rst_n) begin
      req_m       <= 1'b0;
      req_s       <= 1'b0;
      ack_tgl     <= 1'b0;
      gen_range   <= 2'b00;
      mf_m        <= 1'b0;
      gen_maxfreq <= 1'b0;
      ft_m        <= 1'b0;
      gen_ftrim   <= 1'b0;
      rq_m        <= 1'b1;
      gen_ref_int <= 1'b1;
    end else begin
      req_m <= req_tgl;
      req_s <= req_m;
      if (req_s != ack_tgl) begin
        gen_range <= sent_range;
        ack_tgl   <= req_s;
      end
      mf_m        <= maxfreq;
      gen_maxfreq <= mf_m;
      ft_m        <= ftrim;
      gen_ftrim   <= ft_m;
      rq_m        <= ref_int_req;
      gen_ref_int <= rq_m;
    end

  assign rd_data = {range_stat, maxfreq, refst_s, 3'b000, ftrim};

endmodule

module clkcfg_reg_chk (
  input logic       bus_clk,
  input logic       bus_rst_n,
  input logic       gen_clk,
  input logic       gen_rst_n,
  input logic       wr_en,
  input logic       low_power,
  input logic [7:0] rd_data,
  input logic [1:0] gen_range,
  input logic [1:0] range_req,
  input logic [1:0] sent_range,
  input logic       req_tgl,
  input logic       ack_seen
);

  // R3
  reserved_never_applied_chk: assert property (@(posedge gen_clk) disable iff (!gen_rst_n)
    gen_range != 2'b11);

  // R4
  lowpower_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && low_power) |=> $stable(range_req));

  // R8
  inflight_stable_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_tgl != ack_seen) |=> $stable(sent_range));

  // R2
  status_from_xfer_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !$stable(rd_data[7:6]) |-> (rd_data[7:6] == $past(sent_range)));

  // R2
  status_not_reserved_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rd_data[7:6] != 2'b11);

endmodule

bind clkcfg_reg clkcfg_reg_chk u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .gen_clk(gen_clk), .gen_rst_n(gen_rst_n),
  .wr_en(wr_en), .low_power(low_power), .rd_data(rd_data), .gen_range(gen_range),
  .range_req(range_req), .sent_range(sent_range), .req_tgl(req_tgl), .ack_seen(ack_seen)
);

// File: tb/clkcfg_reg_bench.sv
`timescale 1ns/100ps
module clkcfg_reg_bench;

  logic       bus_clk = 0, gen_clk = 0;
  logic       bus_rst_n = 0, gen_rst_n = 0;
  logic       wr_en = 0, low_power = 0, ref_int_req = 1, trim_fuse = 1, debug_mode = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [1:0] gen_range;
  logic       gen_maxfreq, gen_ftrim, gen_ref_int;

  int n_cmp = 0, n_bad = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #3.7 gen_clk = ~gen_clk;

  clkcfg_reg u_clkcfg_reg (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .gen_clk(gen_clk), .gen_rst_n(gen_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .low_power(low_power),
    .ref_int_req(ref_int_req), .trim_fuse(trim_fuse), .debug_mode(debug_mode),
    .gen_range(gen_range), .gen_maxfreq(gen_maxfreq), .gen_ftrim(gen_ftrim),
    .gen_ref_int(gen_ref_int)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (60) @(negedge bus_clk);
  endtask

  task automatic wait_range(input logic [1:0] exp);
    for (int i = 0; i < 60; i++) begin
      if (rd_data[7:6] == exp) break;
      @(negedge bus_clk);
    end
  endtask

  task automatic do_reset(input logic dbg, input logic fuse);
    @(negedge bus_clk);
    bus_rst_n = 0; gen_rst_n = 0; debug_mode = dbg; trim_fuse = fuse; ref_int_req = 1;
    repeat (4) @(negedge bus_clk);
    chk("R1 reset rd_data", rd_data, {7'h08, (dbg ? 1'b0 : fuse)});
    chk("R1 reset gen_range", {6'd0, gen_range}, 8'h00);
    chk("R1 reset gen_ref_int", {7'd0, gen_ref_int}, 8'h01);
    chk("R1 reset gen_maxfreq", {7'd0, gen_maxfreq}, 8'h00);
    bus_rst_n = 1; gen_rst_n = 1;
    debug_mode = ~dbg; trim_fuse = ~fuse;
    settle();
    chk("R6 ftrim after reset", {7'd0, rd_data[0]}, {7'd0, (dbg ? 1'b0 : fuse)});
    chk("R6 gen_ftrim after reset", {7'd0, gen_ftrim}, {7'd0, (dbg ? 1'b0 : fuse)});
    chk("R9 low bits", {5'd0, rd_data[3:1]}, 8'h00);
  endtask

  task automatic test_ranges();
    logic [1:0] codes [3] = '{2'b01, 2'b10, 2'b00};
    foreach (codes[k]) begin
      logic [1:0] prev;
      prev = rd_data[7:6];
      bus_write({codes[k], 6'd0});
      chk("R2 status lags write", {6'd0, rd_data[7:6]}, {6'd0, prev});
      wait_range(codes[k]);
      chk("R2 status after write", {6'd0, rd_data[7:6]}, {6'd0, codes[k]});
      chk("R2 gen_range after write", {6'd0, gen_range}, {6'd0, codes[k]});
    end
  endtask

  task automatic test_reserved();
    bus_write(8'h80);
    wait_range(2'b10);
    bus_write(8'hC0);
    settle();
    chk("R3 reserved status kept", {6'd0, rd_data[7:6]}, 8'h02);
    chk("R3 reserved gen_range kept", {6'd0, gen_range}, 8'h02);
  endtask

  task automatic test_low_power();
    low_power = 1;
    bus_write(8'h61);
    settle();
    chk("R4 low power status kept", {6'd0, rd_data[7:6]}, 8'h02);
    chk("R4 low power gen_range kept", {6'd0, gen_range}, 8'h02);
    chk("R4 other bits taken", {6'd0, rd_data[5], rd_data[0]}, 8'h03);
    low_power = 0;
    bus_write(8'h41);
    wait_range(2'b01);
    chk("R4 accepted after release", {6'd0, rd_data[7:6]}, 8'h01);
  endtask

  task automatic test_bits();
    bus_write(8'h61);
    settle();
    chk("R5 maxfreq read", {7'd0, rd_data[5]}, 8'h01);
    chk("R5 gen_maxfreq set", {7'd0, gen_maxfreq}, 8'h01);
    chk("R6 gen_ftrim set", {7'd0, gen_ftrim}, 8'h01);
    bus_write(8'h40);
    settle();
    chk("R5 gen_maxfreq clear", {7'd0, gen_maxfreq}, 8'h00);
    chk("R6 ftrim cleared", {7'd0, rd_data[0]}, 8'h00);
    chk("R6 gen_ftrim cleared", {7'd0, gen_ftrim}, 8'h00);
    chk("R9 low bits", {5'd0, rd_data[3:1]}, 8'h00);
  endtask

  task automatic test_ref();
    @(negedge bus_clk);
    ref_int_req = 0;
    @(negedge bus_clk);
    chk("R7 ref status lags", {7'd0, rd_data[4]}, 8'h01);
    settle();
    chk("R7 ref status external", {7'd0, rd_data[4]}, 8'h00);
    chk("R7 gen_ref_int external", {7'd0, gen_ref_int}, 8'h00);
    ref_int_req = 1;
    settle();
    chk("R7 ref status internal", {7'd0, rd_data[4]}, 8'h01);
  endtask

  task automatic test_back_to_back();
    int bad = 0;
    @(negedge bus_clk);
    wr_en = 1; wr_data = 8'h00;
    @(negedge bus_clk);
    wr_data = 8'h80;
    @(negedge bus_clk);
    wr_data = 8'h40;
    @(negedge bus_clk);
    wr_en = 0;
    for (int i = 0; i < 100; i++) begin
      if (rd_data[7:6] == 2'b11) bad++;
      @(negedge bus_clk);
    end
    chk("R8 no reserved shown", bad[7:0], 8'h00);
    chk("R8 final status", {6'd0, rd_data[7:6]}, 8'h01);
    chk("R8 final gen_range", {6'd0, gen_range}, 8'h01);
  endtask

  initial begin
    do_reset(1'b0, 1'b1);
    test_ranges();
    test_reserved();
    test_low_power();
    test_bits();
    test_ref();
    test_back_to_back();
    do_reset(1'b1, 1'b1);
    do_reset(1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bus_clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule